// File: doc/BRIEF.md
# Split-Half RAM Access Protection

This block guards a small internal RAM that a CPU reaches through a memory window. The RAM is 1 KB and is split into a lower and an upper 512-byte half. CPU address bit 9 picks the half and bits 8:0 index inside it. Higher address bits are not decoded, so the window repeats. Two CPU-writable registers set the access rules. A configuration register holds a global RAM enable. A protection register holds a read-allow bit and a write-allow bit for each half.

A read returns one of three values: the RAM byte, a forced zero, or the byte last seen on the CPU data bus (open bus). The open-bus byte comes in on an input supplied by the surrounding system. A write that the rules forbid leaves the RAM untouched. The read result appears one clock after the request and stays on the output until the next read. Reset clears the rules but leaves the RAM contents as they were.

Top module: `ramprot_top`

## Requirements
- R1: The RAM location is (cpuAddr bit 9) × 512 + cpuAddr[8:0]. Address bits 15:10 are ignored, so a byte written through one address is read back through any address that agrees in bits 9:0.
- R2: A register write whose address ANDed with 0xE001 equals 0x8000 loads the global enable from data bit 5. When that bit is 0, all four permission bits are also cleared, and they stay cleared after the enable is set again.
- R3: A register write whose address ANDed with 0xE001 equals 0xA001 loads the permissions only while the global enable is 1: bit 7 = upper read, bit 6 = upper write, bit 5 = lower read, bit 4 = lower write. While the enable is 0, this write has no effect.
- R4: A read while the global enable is 0 returns the busLast value captured in the request cycle.
- R5: A read while neither half has read permission returns the captured busLast value.
- R6: A read of a half without read permission returns 0x00 when the other half is readable.
- R7: A write is discarded when the global enable is 0 or the addressed half lacks write permission. A later permitted read of that location returns the old byte.
- R8: rdValid is high exactly one cycle after a cycle with ramRead high. rdData changes only in that cycle and holds its value otherwise.
- R9: Reset clears the enable and all permissions, drives rdValid low and rdData to 0x00, and does not alter the RAM contents.
- R10: When ramRead and ramWrite are both high in the same cycle, the read is served and the write is dropped.
- R11: A register write whose masked address is neither 0x8000 nor 0xA001 changes neither the enable nor the permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | CPU write to the register space this cycle |
| ramRead | input | 1 | CPU read of the RAM window this cycle |
| ramWrite | input | 1 | CPU write to the RAM window this cycle |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| busLast | input | 8 | Last byte seen on the CPU data bus |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | rdData holds a fresh result |

## Verification
The bench goes after the boundary between a forced zero and open bus. It reads one half while the other half is readable, and again while neither half is. A design that tested only the addressed half's permission would return zero where open bus is due. The bench turns the enable off and back on and then reads. A design that only gated permissions with the enable, instead of clearing them, would bring back the old permissions. It also writes the protection register while the enable is off, uses mirrored register and RAM addresses, and raises read and write together. A wrong design there would leak permissions, decode too few address bits, or corrupt RAM during a read.

// File: rtl/ramprot_pkg.sv
package ramprot_pkg;

  // Read result source chosen at request time
  typedef enum logic [1:0] {
    RD_OPEN = 2'd0,
    RD_ZERO = 2'd1,
    RD_RAM  = 2'd2
  } rdSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   rdFire;
    logic   ramWe;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;

endpackage

// File: rtl/ramprot_ctrl.sv
module ramprot_ctrl
  import ramprot_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DW           = 8,
  parameter int HALF_AW      = 9,
  parameter logic [ADDR_W-1:0] REG_MASK  = 16'hE001,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'h8000,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hA001,
  parameter int EN_BIT       = 5,
  parameter int LOW_WR_BIT   = 4,
  parameter int LOW_RD_BIT   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              ramRead,
  input  logic              ramWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DW-1:0]     cpuData,
  output ctrlStrobe_t       strobe,
  output logic              masterEn,
  output logic [1:0]        permRd,
  output logic [1:0]        permWr
);

  localparam int HALVES   = 2;
  localparam int BIT_STEP = 2;

  logic cfgWr;
  logic protWr;
  logic halfSel;
  logic wipe;

  assign cfgWr   = regWrite && ((cpuAddr & REG_MASK) == CFG_ADDR);
  assign protWr  = regWrite && ((cpuAddr & REG_MASK) == PROT_ADDR);
  assign halfSel = cpuAddr[HALF_AW];
  assign wipe    = cfgWr && !cpuData[EN_BIT];

  // Global enable
  always_ff @(posedge clk) begin
    if (!rstN)      masterEn <= 1'b0;
    else if (cfgWr) masterEn <= cpuData[EN_BIT];
  end

  // Per-half permission bits
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic rdQ;
    logic wrQ;
    always_ff @(posedge clk) begin
      if (!rstN || wipe) begin
        rdQ <= 1'b0;
        wrQ <= 1'b0;
      end else if (protWr && masterEn) begin
        rdQ <= cpuData[LOW_RD_BIT + BIT_STEP*h];
        wrQ <= cpuData[LOW_WR_BIT + BIT_STEP*h];
      end
    end
    assign permRd[h] = rdQ;
    assign permWr[h] = wrQ;
  end

  // Access decisions use the state before any same-cycle update
  always_comb begin
    strobe.rdFire = ramRead;
    strobe.ramWe  = ramWrite && !ramRead && masterEn && permWr[halfSel];
    if (!masterEn || (permRd == 2'b00)) strobe.rdSrc = RD_OPEN;
    else if (!permRd[halfSel])          strobe.rdSrc = RD_ZERO;
    else                                strobe.rdSrc = RD_RAM;
  end

endmodule

// File: rtl/ramprot_dpath.sv
module ramprot_dpath
  import ramprot_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DW      = 8,
  parameter int HALF_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DW-1:0]     cpuData,
  input  logic [DW-1:0]     busLast,
  output logic [DW-1:0]     rdData,
  output logic              rdValid
);

  localparam int RAM_AW = HALF_AW + 1;
  localparam int DEPTH  = 1 << RAM_AW;

  logic [DW-1:0]     mem [DEPTH];
  logic [RAM_AW-1:0] ramIdx;
  logic [DW-1:0]     ramQ;
  logic [DW-1:0]     busQ;
  rdSrc_e            srcQ;

  // Half select bit on top of the in-half index
  assign ramIdx = {cpuAddr[HALF_AW], cpuAddr[HALF_AW-1:0]};

  // Storage: no reset, contents survive it
  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[ramIdx] <= cpuData;
    if (strobe.rdFire) ramQ <= mem[ramIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ    <= '0;
      srcQ    <= RD_OPEN;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdFire;
      if (strobe.rdFire) begin
        busQ <= busLast;
        srcQ <= strobe.rdSrc;
      end
    end
  end

  always_comb begin
    case (srcQ)
      RD_RAM:  rdData = ramQ;
      RD_ZERO: rdData = '0;
      default: rdData = busQ;
    endcase
  end

endmodule

// File: rtl/ramprot_top.sv
module ramprot_top
  import ramprot_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DW      = 8,
  parameter int HALF_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              ramRead,
  input  logic              ramWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DW-1:0]     cpuData,
  input  logic [DW-1:0]     busLast,
  output logic [DW-1:0]     rdData,
  output logic              rdValid
);

  ctrlStrobe_t strobe;
  logic        masterEn;
  logic [1:0]  permRd;
  logic [1:0]  permWr;

  ramprot_ctrl #(.ADDR_W(ADDR_W), .DW(DW), .HALF_AW(HALF_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .ramRead(ramRead),
    .ramWrite(ramWrite), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .strobe(strobe), .masterEn(masterEn), .permRd(permRd), .permWr(permWr)
  );

  ramprot_dpath #(.ADDR_W(ADDR_W), .DW(DW), .HALF_AW(HALF_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .busLast(busLast), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/ramprot_checker.sv
module ramprot_checker #(
  parameter int ADDR_W  = 16,
  parameter int DW      = 8,
  parameter int HALF_AW = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrite,
  input logic              ramRead,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DW-1:0]     cpuData,
  input logic [DW-1:0]     busLast,
  input logic [DW-1:0]     rdData,
  input logic              rdValid,
  input logic              masterEn,
  input logic [1:0]        permRd,
  input logic [1:0]        permWr
);

  logic cfgHit;
  logic protHit;
  assign cfgHit  = regWrite && ((cpuAddr & 16'hE001) == 16'h8000);
  assign protHit = regWrite && ((cpuAddr & 16'hE001) == 16'hA001);

  assert_valid_after_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramRead |=> rdValid);
  assert_no_valid_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ramRead |=> !rdValid);
  assert_data_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ramRead |=> $stable(rdData));
  assert_disable_wipes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHit && !cpuData[5]) |=> (!masterEn && permRd == 2'b00 && permWr == 2'b00));
  assert_perm_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> (permRd == 2'b00 && permWr == 2'b00));
  assert_prot_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (protHit && !masterEn) |=> ($stable(permRd) && $stable(permWr)));
  assert_open_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ramRead && !masterEn) |=> (rdData == $past(busLast)));
  assert_open_none_readable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ramRead && permRd == 2'b00) |=> (rdData == $past(busLast)));
  assert_zero_protected_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ramRead && masterEn && permRd != 2'b00 && !permRd[cpuAddr[HALF_AW]])
    |=> (rdData == '0));

endmodule

bind ramprot_top ramprot_checker #(.ADDR_W(ADDR_W), .DW(DW), .HALF_AW(HALF_AW)) u_chk (
  .clk(clk), .rstN(rstN), .regWrite(regWrite), .ramRead(ramRead),
  .cpuAddr(cpuAddr), .cpuData(cpuData), .busLast(busLast), .rdData(rdData),
  .rdValid(rdValid), .masterEn(masterEn), .permRd(permRd), .permWr(permWr)
);

// File: tb/sim_ramprot_top.sv
`timescale 1ns/1ps
module sim_ramprot_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic        ramRead = 1'b0;
  logic        ramWrite = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic [7:0]  busLast = '0;
  logic [7:0]  rdData;
  logic        rdValid;

  always #2 clk = ~clk;

  ramprot_top u0 (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .ramRead(ramRead),
    .ramWrite(ramWrite), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .busLast(busLast), .rdData(rdData), .rdValid(rdValid)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural reference model
  byte unsigned mdlMem [1024];
  bit  mdlEn;
  bit  mdlRd [2];
  bit  mdlWr [2];
  bit  expValid;
  byte unsigned expData;
  string tag;

  function automatic byte unsigned mdlRead(input logic [15:0] a, input byte unsigned bus);
    int h = a[9];
    if (!mdlEn) return bus;
    if (!mdlRd[0] && !mdlRd[1]) return bus;
    if (!mdlRd[h]) return 8'h00;
    return mdlMem[a[9:0]];
  endfunction

  task automatic check();
    total++;
    if (rdValid !== expValid) begin
      bad++;
      $display("FAIL %s rdValid actual=%0b expected=%0b", tag, rdValid, expValid);
    end
    total++;
    if (rdData !== expData) begin
      bad++;
      $display("FAIL %s rdData actual=%02h expected=%02h", tag, rdData, expData);
    end
  endtask

  // kind: 0 idle, 1 register write, 2 read, 3 write, 4 read+write
  task automatic step(input int kind, input logic [15:0] a, input logic [7:0] d,
                      input logic [7:0] bus, input string t);
    int h = a[9];
    tag = t;
    regWrite = (kind == 1);
    ramRead  = (kind == 2 || kind == 4);
    ramWrite = (kind == 3 || kind == 4);
    cpuAddr  = a;
    cpuData  = d;
    busLast  = bus;
    expValid = ramRead;
    if (ramRead) expData = mdlRead(a, bus);
    if (kind == 3 && mdlEn && mdlWr[h]) mdlMem[a[9:0]] = d;
    if (kind == 1) begin
      if ((a & 16'hE001) == 16'h8000) begin
        mdlEn = d[5];
        if (!d[5]) begin
          mdlRd[0] = 0; mdlRd[1] = 0; mdlWr[0] = 0; mdlWr[1] = 0;
        end
      end else if ((a & 16'hE001) == 16'hA001 && mdlEn) begin
        mdlRd[1] = d[7]; mdlWr[1] = d[6]; mdlRd[0] = d[5]; mdlWr[0] = d[4];
      end
    end
    @(posedge clk);
    @(negedge clk);
    check();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    regWrite = 0; ramRead = 0; ramWrite = 0;
    mdlEn = 0; mdlRd[0] = 0; mdlRd[1] = 0; mdlWr[0] = 0; mdlWr[1] = 0;
    expValid = 0; expData = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tag = "R9 reset";
    check();
  endtask

  initial begin
    doReset();
    // R4: read while disabled
    step(2, 16'h6000, 8'h00, 8'h5A, "R4 off read");
    step(0, 16'h0000, 8'h00, 8'hFF, "R8 hold");
    // R3: protection write ignored while off, then enable
    step(1, 16'hA001, 8'hF0, 8'h00, "R3 ignored");
    step(1, 16'h8000, 8'h20, 8'h00, "R2 enable");
    step(2, 16'h6000, 8'h00, 8'hC3, "R5 none readable");
    // full permissions and fill
    step(1, 16'hA001, 8'hF0, 8'h00, "R3 load");
    step(3, 16'h6000, 8'h11, 8'h00, "R1 wr");
    step(3, 16'h6200, 8'h22, 8'h00, "R1 wr");
    step(3, 16'h61FF, 8'h33, 8'h00, "R1 wr");
    step(3, 16'h63FF, 8'h44, 8'h00, "R1 wr");
    step(3, 16'h6005, 8'h55, 8'h00, "R1 wr");
    step(2, 16'h6000, 8'h00, 8'h99, "R1 rd lower");
    step(2, 16'h6200, 8'h00, 8'h99, "R1 rd upper");
    step(2, 16'h61FF, 8'h00, 8'h99, "R1 rd lower end");
    step(2, 16'h63FF, 8'h00, 8'h99, "R1 rd upper end");
    step(2, 16'h7C05, 8'h00, 8'h99, "R1 mirror");
    step(0, 16'h0000, 8'h00, 8'h77, "R8 hold");
    // R6: only lower readable
    step(1, 16'hA001, 8'h20, 8'h00, "R3 lower rd");
    step(2, 16'h6200, 8'h00, 8'h99, "R6 upper zero");
    step(2, 16'h6000, 8'h00, 8'h99, "R6 lower ok");
    step(1, 16'hA001, 8'h80, 8'h00, "R3 upper rd");
    step(2, 16'h6000, 8'h00, 8'h99, "R6 lower zero");
    step(2, 16'h6200, 8'h00, 8'h99, "R6 upper ok");
    step(1, 16'hA001, 8'h00, 8'h00, "R3 none");
    step(2, 16'h6200, 8'h00, 8'hAB, "R5 open");
    // R7: writes without permission
    step(1, 16'hA001, 8'hA0, 8'h00, "R3 read only");
    step(3, 16'h6000, 8'hEE, 8'h00, "R7 wr dropped");
    step(3, 16'h6200, 8'hEE, 8'h00, "R7 wr dropped");
    step(2, 16'h6000, 8'h00, 8'h00, "R7 lower kept");
    step(2, 16'h6200, 8'h00, 8'h00, "R7 upper kept");
    step(1, 16'hA001, 8'hE0, 8'h00, "R3 upper wr");
    step(3, 16'h6200, 8'h66, 8'h00, "R7 upper wr");
    step(3, 16'h6000, 8'h67, 8'h00, "R7 lower dropped");
    step(2, 16'h6200, 8'h00, 8'h00, "R7 upper new");
    step(2, 16'h6000, 8'h00, 8'h00, "R7 lower old");
    // R2: disable wipes, mirrored config address
    step(1, 16'h9FFE, 8'h00, 8'h00, "R2 disable");
    step(3, 16'h6200, 8'h70, 8'h00, "R7 off write");
    step(2, 16'h6200, 8'h00, 8'h3C, "R4 off");
    step(1, 16'h8000, 8'h20, 8'h00, "R2 reenable");
    step(2, 16'h6200, 8'h00, 8'h4D, "R2 perms cleared");
    // R11: other registers do nothing
    step(1, 16'hA001, 8'hF0, 8'h00, "R3 load");
    step(1, 16'h8001, 8'h00, 8'h00, "R11 other");
    step(1, 16'hA000, 8'h00, 8'h00, "R11 other");
    step(1, 16'hC001, 8'h00, 8'h00, "R11 other");
    step(1, 16'hE000, 8'h00, 8'h00, "R11 other");
    step(2, 16'h6200, 8'h00, 8'h12, "R11 still ok");
    step(3, 16'h6000, 8'h81, 8'h00, "R11 write ok");
    step(2, 16'h6000, 8'h00, 8'h12, "R11 read back");
    // R10: read and write together
    step(4, 16'h6000, 8'hBB, 8'h00, "R10 rw");
    step(2, 16'h6000, 8'h00, 8'h00, "R10 not written");
    // R9: reset keeps RAM
    doReset();
    step(2, 16'h6000, 8'h00, 8'h5F, "R9 perms gone");
    step(1, 16'h8000, 8'h20, 8'h00, "R2 enable");
    step(1, 16'hA001, 8'hF0, 8'h00, "R3 load");
    step(2, 16'h6200, 8'h00, 8'h00, "R9 ram kept");
    step(2, 16'h63FF, 8'h00, 8'h00, "R9 ram kept");
    step(0, 16'h0000, 8'h00, 8'h00, "R8 hold");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule